// File: doc/BRIEF.md
# VLIW Bundle Lane Dispatcher

The dispatcher accepts a pair of fixed-format long instruction words per clock and sends every instruction in them straight to an execution lane of its own. There are six lanes: three slots in each of two bundles. No dependence tracking is done in hardware. The scheduling order is taken to be already settled when the bundles arrive, and successive pairs are issued strictly in arrival order. Each bundle carries a template code that says which unit class, out of integer, memory, floating point and branch, may sit in each of its three slots. The lanes are therefore heterogeneous, and the position of an instruction fixes which unit takes it.

Slots that the scheduler could not fill hold an empty opcode. An empty slot never raises its lane's valid, but it is counted as lost issue capacity. Filled slots are counted alongside. A pair whose template is unknown is withheld from issue and flagged for one cycle. A pair in which an instruction's class disagrees with its template is treated the same way, under a separate flag. Backpressure is all-or-nothing: the input is ready only while every lane is ready, so both bundles of a pair always go in together.

Top module: `vliw_dispatch`

## Requirements
- R1: Bundle b of the input pair occupies bits [128*b +: 128]. Within a bundle, bits [4:0] are the template, and slot k is bits [5+41*k +: 41]. Slot k of bundle b is delivered on lane 3*b+k.
- R2: Within a slot, bits [40:37] are the opcode, [36:21] the immediate, [20:14] source 2, [13:7] source 1 and [6:0] the destination index. Opcode 0 marks an empty slot. For any other opcode the class is opcode[3:2], with 0 integer, 1 memory, 2 floating point and 3 branch.
- R3: Supported templates and their classes for slots 0/1/2 are: 0 = mem/int/int, 1 = mem/mem/int, 2 = mem/fp/int, 3 = mem/int/br, 4 = int/int/br, 5 = mem/mem/fp, 6 = fp/fp/br, 7 = mem/fp/br. Template values 8 to 31 are unsupported. Each lane's class output shows its slot's template class.
- R4: in_ready_o is high exactly when every bit of lane_ready_i is high. A pair is taken on a rising edge where in_valid_i and in_ready_o are both high, and it is never taken in part.
- R5: After a legal pair is taken, every non-empty slot appears on its lane on the next cycle, with valid high and with its opcode, immediate, indices and class. The lanes of empty slots keep valid low.
- R6: A lane with valid high and its ready low holds valid and all its fields. A valid lane whose ready is high while some other lane's ready is low drops valid on the next cycle.
- R7: If any non-empty slot of a pair with legal templates has a class that differs from its template, no lane of the pair issues. err_cls_o is then high for the one cycle after the pair is taken, and the counters do not change.
- R8: If either bundle carries an unsupported template, no lane issues. err_tmpl_o is then high for the one cycle after the pair is taken, err_cls_o stays low, and the counters do not change.
- R9: For each pair that issues, the filled counter grows by the number of non-empty slots and the empty counter by the number of empty slots, visible on the next cycle. Both counters saturate at their maximum value.
- R10: While reset is high, and on the first cycle after it, every lane valid, both error flags and both counters are zero.
- R11: After an edge on which in_ready_o is high and in_valid_i is low, every lane valid is low and both error flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid_i | input | 1 | Bundle pair present |
| in_ready_o | output | 1 | Pair can be taken this cycle |
| in_bundles_i | input | 256 | Two 128-bit bundles, bundle 0 in the low half |
| lane_ready_i | input | 6 | Per-lane ready from the execution units |
| lane_valid_o | output | 6 | Per-lane instruction valid |
| lane_cls_o | output | 12 | Per-lane unit class, 2 bits each |
| lane_op_o | output | 24 | Per-lane opcode, 4 bits each |
| lane_imm_o | output | 96 | Per-lane immediate, 16 bits each |
| lane_dst_o | output | 42 | Per-lane destination index, 7 bits each |
| lane_src1_o | output | 42 | Per-lane source 1 index, 7 bits each |
| lane_src2_o | output | 42 | Per-lane source 2 index, 7 bits each |
| err_tmpl_o | output | 1 | Unsupported template seen, one-cycle pulse |
| err_cls_o | output | 1 | Slot class disagrees with template, one-cycle pulse |
| cnt_filled_o | output | 16 | Saturating count of issued non-empty slots |
| cnt_empty_o | output | 16 | Saturating count of issued empty slots |

## Verification
Every result the dispatcher registers, meaning the lane fields, the error pulses and the counters, is due one cycle after the rising edge that takes a pair. Only in_ready_o follows lane_ready_i in the same cycle. The bench changes its inputs on falling edges and reads the registered results on the falling edge that follows the taking edge. It reads them again one cycle later to confirm that an error pulse has ended, that idle lanes have cleared, and that a stalled lane still holds its fields while its neighbours have drained.

// File: rtl/vliw_pkg.sv
package vliw_pkg;
  localparam int TMPL_W   = 5;
  localparam int SLOT_W   = 41;
  localparam int OP_W     = 4;
  localparam int IMM_W    = 16;
  localparam int REG_W    = 7;
  localparam int SLOTS    = 3;
  localparam int CLS_W    = 2;
  localparam int BUNDLE_W = TMPL_W + SLOTS * SLOT_W;

  typedef logic [CLS_W-1:0] ucls_t;
  localparam ucls_t CLS_INT = 2'd0;
  localparam ucls_t CLS_MEM = 2'd1;
  localparam ucls_t CLS_FP  = 2'd2;
  localparam ucls_t CLS_BR  = 2'd3;

  typedef struct packed {
    logic             nop;
    logic [OP_W-1:0]  op;
    logic [IMM_W-1:0] imm;
    logic [REG_W-1:0] dst;
    logic [REG_W-1:0] src1;
    logic [REG_W-1:0] src2;
  } slot_t;

  typedef struct packed {
    logic                   legal;
    ucls_t [SLOTS-1:0]      cls;
  } tmpl_t;

  // Slot classes listed as {slot2, slot1, slot0}.
  function automatic tmpl_t tmpl_decode(input logic [TMPL_W-1:0] code);
    tmpl_t r;
    r.legal = 1'b1;
    case (code)
      5'd0:    r.cls = {CLS_INT, CLS_INT, CLS_MEM};
      5'd1:    r.cls = {CLS_INT, CLS_MEM, CLS_MEM};
      5'd2:    r.cls = {CLS_INT, CLS_FP,  CLS_MEM};
      5'd3:    r.cls = {CLS_BR,  CLS_INT, CLS_MEM};
      5'd4:    r.cls = {CLS_BR,  CLS_INT, CLS_INT};
      5'd5:    r.cls = {CLS_FP,  CLS_MEM, CLS_MEM};
      5'd6:    r.cls = {CLS_BR,  CLS_FP,  CLS_FP};
      5'd7:    r.cls = {CLS_BR,  CLS_FP,  CLS_MEM};
      default: begin
        r.legal = 1'b0;
        r.cls   = '0;
      end
    endcase
    return r;
  endfunction
endpackage

// File: rtl/vliw_slot_decode.sv
module vliw_slot_decode
  import vliw_pkg::*;
(
  input  logic [SLOT_W-1:0] slot_i,
  output slot_t             dec_o
);
  always_comb begin
    dec_o.op   = slot_i[SLOT_W-1 -: OP_W];
    dec_o.imm  = slot_i[3*REG_W +: IMM_W];
    dec_o.src2 = slot_i[2*REG_W +: REG_W];
    dec_o.src1 = slot_i[REG_W +: REG_W];
    dec_o.dst  = slot_i[0 +: REG_W];
    dec_o.nop  = (dec_o.op == '0);
  end
endmodule

// File: rtl/vliw_bundle_check.sv
module vliw_bundle_check
  import vliw_pkg::*;
(
  input  logic [BUNDLE_W-1:0] bundle_i,
  output slot_t [SLOTS-1:0]   slots_o,
  output ucls_t [SLOTS-1:0]   lane_cls_o,
  output logic                tmpl_bad_o,
  output logic                cls_bad_o
);
  tmpl_t             tinfo;
  logic [SLOTS-1:0]  mis;

  assign tinfo = tmpl_decode(bundle_i[TMPL_W-1:0]);

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    vliw_slot_decode u_dec (
      .slot_i (bundle_i[TMPL_W + k*SLOT_W +: SLOT_W]),
      .dec_o  (slots_o[k])
    );
    assign mis[k] = !slots_o[k].nop &&
                    (slots_o[k].op[OP_W-1 -: CLS_W] != tinfo.cls[k]);
  end

  assign lane_cls_o = tinfo.cls;
  assign tmpl_bad_o = !tinfo.legal;
  assign cls_bad_o  = tinfo.legal && (|mis);
endmodule

// File: rtl/vliw_lane_reg.sv
module vliw_lane_reg
  import vliw_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             advance_i,
  input  logic             load_i,
  input  logic [OP_W-1:0]  op_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [REG_W-1:0] dst_i,
  input  logic [REG_W-1:0] src1_i,
  input  logic [REG_W-1:0] src2_i,
  input  ucls_t            cls_i,
  input  logic             ready_i,
  output logic             valid_o,
  output logic [OP_W-1:0]  op_o,
  output logic [IMM_W-1:0] imm_o,
  output logic [REG_W-1:0] dst_o,
  output logic [REG_W-1:0] src1_o,
  output logic [REG_W-1:0] src2_o,
  output ucls_t            cls_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      op_o    <= '0;
      imm_o   <= '0;
      dst_o   <= '0;
      src1_o  <= '0;
      src2_o  <= '0;
      cls_o   <= '0;
    end else if (advance_i) begin
      valid_o <= load_i;
      op_o    <= op_i;
      imm_o   <= imm_i;
      dst_o   <= dst_i;
      src1_o  <= src1_i;
      src2_o  <= src2_i;
      cls_o   <= cls_i;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end

  AST_LANE_HOLD: assert property (@(posedge clk) disable iff (rst)
    valid_o && !ready_i |=> valid_o && $stable(op_o) && $stable(imm_o) &&
      $stable(dst_o) && $stable(src1_o) && $stable(src2_o) && $stable(cls_o)); // R6
  AST_LANE_DRAIN: assert property (@(posedge clk) disable iff (rst)
    valid_o && ready_i && !advance_i |=> !valid_o); // R6
  AST_LANE_NO_EMPTY: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> op_o != '0); // R5
endmodule

// File: rtl/vliw_slot_counter.sv
module vliw_slot_counter #(
  parameter int CNT_W = 16,
  parameter int ADD_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ADD_W-1:0] add_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam int SUM_W = CNT_W + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [SUM_W-1:0] sum;
  assign sum = {1'b0, cnt_o} + SUM_W'(add_i);

  always_ff @(posedge clk) begin
    if (rst)               cnt_o <= '0;
    else if (sum[CNT_W])   cnt_o <= CNT_MAX;
    else                   cnt_o <= sum[CNT_W-1:0];
  end

  AST_CNT_MONO: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> cnt_o >= $past(cnt_o)); // R9
  AST_CNT_SAT: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(cnt_o) == CNT_MAX |-> cnt_o == CNT_MAX); // R9
endmodule

// File: rtl/vliw_dispatch.sv
module vliw_dispatch
  import vliw_pkg::*;
#(
  parameter int NUM_BUNDLES = 2,
  parameter int CNT_W       = 16,
  localparam int LANES      = NUM_BUNDLES * SLOTS,
  localparam int ADD_W      = $clog2(LANES + 1)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_valid_i,
  output logic                        in_ready_o,
  input  logic [NUM_BUNDLES*BUNDLE_W-1:0] in_bundles_i,
  input  logic [LANES-1:0]            lane_ready_i,
  output logic [LANES-1:0]            lane_valid_o,
  output logic [LANES*CLS_W-1:0]      lane_cls_o,
  output logic [LANES*OP_W-1:0]       lane_op_o,
  output logic [LANES*IMM_W-1:0]      lane_imm_o,
  output logic [LANES*REG_W-1:0]      lane_dst_o,
  output logic [LANES*REG_W-1:0]      lane_src1_o,
  output logic [LANES*REG_W-1:0]      lane_src2_o,
  output logic                        err_tmpl_o,
  output logic                        err_cls_o,
  output logic [CNT_W-1:0]            cnt_filled_o,
  output logic [CNT_W-1:0]            cnt_empty_o
);
  slot_t [LANES-1:0]        lane_slot;
  ucls_t [LANES-1:0]        lane_cls;
  logic [NUM_BUNDLES-1:0]   b_tmpl_bad;
  logic [NUM_BUNDLES-1:0]   b_cls_bad;

  logic advance, accept, any_tmpl_bad, any_cls_bad, issue;
  logic [ADD_W-1:0] fill_add, empty_add;

  for (genvar b = 0; b < NUM_BUNDLES; b++) begin : g_bundle
    vliw_bundle_check u_chk (
      .bundle_i   (in_bundles_i[b*BUNDLE_W +: BUNDLE_W]),
      .slots_o    (lane_slot[b*SLOTS +: SLOTS]),
      .lane_cls_o (lane_cls[b*SLOTS +: SLOTS]),
      .tmpl_bad_o (b_tmpl_bad[b]),
      .cls_bad_o  (b_cls_bad[b])
    );
  end

  // Pair-level handshake: all lanes must be free, both bundles go together.
  assign advance      = &lane_ready_i;
  assign in_ready_o   = advance;
  assign accept       = in_valid_i && advance;
  assign any_tmpl_bad = |b_tmpl_bad;
  assign any_cls_bad  = |b_cls_bad;
  assign issue        = accept && !any_tmpl_bad && !any_cls_bad;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    vliw_lane_reg u_lane (
      .clk       (clk),
      .rst       (rst),
      .advance_i (advance),
      .load_i    (issue && !lane_slot[l].nop),
      .op_i      (lane_slot[l].op),
      .imm_i     (lane_slot[l].imm),
      .dst_i     (lane_slot[l].dst),
      .src1_i    (lane_slot[l].src1),
      .src2_i    (lane_slot[l].src2),
      .cls_i     (lane_cls[l]),
      .ready_i   (lane_ready_i[l]),
      .valid_o   (lane_valid_o[l]),
      .op_o      (lane_op_o[l*OP_W +: OP_W]),
      .imm_o     (lane_imm_o[l*IMM_W +: IMM_W]),
      .dst_o     (lane_dst_o[l*REG_W +: REG_W]),
      .src1_o    (lane_src1_o[l*REG_W +: REG_W]),
      .src2_o    (lane_src2_o[l*REG_W +: REG_W]),
      .cls_o     (lane_cls_o[l*CLS_W +: CLS_W])
    );
  end

  // Slot accounting for the pair being issued.
  always_comb begin
    fill_add  = '0;
    empty_add = '0;
    if (issue) begin
      for (int l = 0; l < LANES; l++) begin
        if (lane_slot[l].nop) empty_add = empty_add + ADD_W'(1);
        else                  fill_add  = fill_add  + ADD_W'(1);
      end
    end
  end

  vliw_slot_counter #(.CNT_W(CNT_W), .ADD_W(ADD_W)) u_cnt_fill (
    .clk   (clk),
    .rst   (rst),
    .add_i (fill_add),
    .cnt_o (cnt_filled_o)
  );

  vliw_slot_counter #(.CNT_W(CNT_W), .ADD_W(ADD_W)) u_cnt_empty (
    .clk   (clk),
    .rst   (rst),
    .add_i (empty_add),
    .cnt_o (cnt_empty_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      err_tmpl_o <= 1'b0;
      err_cls_o  <= 1'b0;
    end else begin
      err_tmpl_o <= accept && any_tmpl_bad;
      err_cls_o  <= accept && !any_tmpl_bad && any_cls_bad;
    end
  end

  AST_CLS_ERR_SILENT: assert property (@(posedge clk) disable iff (rst)
    err_cls_o |-> lane_valid_o == '0); // R7
  AST_CLS_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
    err_cls_o |-> !$past(rst) && $past(in_valid_i && in_ready_o)); // R7
  AST_TMPL_ERR_SILENT: assert property (@(posedge clk) disable iff (rst)
    err_tmpl_o |-> lane_valid_o == '0 && !err_cls_o); // R8
  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    !in_valid_i && in_ready_o |=> lane_valid_o == '0 && !err_tmpl_o && !err_cls_o); // R11
  AST_RESET_CLEAR: assert property (@(posedge clk)
    $past(rst) |-> lane_valid_o == '0 && !err_tmpl_o && !err_cls_o); // R10
endmodule

// File: tb/tb_vliw_dispatch.sv
module tb_vliw_dispatch;
  localparam int CW = 4;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [255:0] in_bundles = '0;
  logic [5:0] lane_ready = '1;
  logic in_ready;
  logic [5:0] lane_valid;
  logic [11:0] lane_cls;
  logic [23:0] lane_op;
  logic [95:0] lane_imm;
  logic [41:0] lane_dst, lane_src1, lane_src2;
  logic err_tmpl, err_cls;
  logic [CW-1:0] cnt_fill, cnt_empty;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  logic [40:0] s [6];
  logic [4:0]  tm [2];
  int exp_fill = 0;
  int exp_empty = 0;

  always #5 clk = ~clk;

  vliw_dispatch #(.NUM_BUNDLES(2), .CNT_W(CW)) dut (
    .clk(clk), .rst(rst), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_bundles_i(in_bundles), .lane_ready_i(lane_ready),
    .lane_valid_o(lane_valid), .lane_cls_o(lane_cls), .lane_op_o(lane_op),
    .lane_imm_o(lane_imm), .lane_dst_o(lane_dst), .lane_src1_o(lane_src1),
    .lane_src2_o(lane_src2), .err_tmpl_o(err_tmpl), .err_cls_o(err_cls),
    .cnt_filled_o(cnt_fill), .cnt_empty_o(cnt_empty)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // R2 slot layout and R1 bundle layout
  function automatic logic [40:0] mk_s(input logic [3:0] op, input logic [15:0] imm,
                                       input logic [6:0] d, input logic [6:0] a, input logic [6:0] b);
    return {op, imm, b, a, d};
  endfunction

  // R3 template table, returns class of slot k, or 4 for unsupported
  function automatic int tb_cls(input logic [4:0] t, input int k);
    int c [8][3] = '{'{1,0,0}, '{1,1,0}, '{1,2,0}, '{1,0,3},
                     '{0,0,3}, '{1,1,2}, '{2,2,3}, '{1,2,3}};
    if (t > 7) return 4;
    return c[t][k];
  endfunction

  function automatic int pair_status();  // 0 ok, 1 class mismatch, 2 bad template
    int st = 0;
    for (int b = 0; b < 2; b++) if (tm[b] > 7) return 2;
    for (int l = 0; l < 6; l++)
      if (s[l][40:37] != 0 && int'(s[l][40:39]) != tb_cls(tm[l/3], l%3)) st = 1;
    return st;
  endfunction

  task automatic present();
    in_bundles = {s[5], s[4], s[3], tm[1], s[2], s[1], s[0], tm[0]};
    in_valid = 1'b1;
  endtask

  task automatic model_take();
    if (pair_status() == 0)
      for (int l = 0; l < 6; l++) begin
        if (s[l][40:37] == 0) exp_empty = (exp_empty + 1 > CMAX) ? CMAX : exp_empty + 1;
        else                  exp_fill  = (exp_fill + 1 > CMAX) ? CMAX : exp_fill + 1;
      end
  endtask

  // Present a pair at a falling edge, let it be taken, end at next falling edge.
  task automatic send_pair();
    present();
    @(posedge clk);
    model_take();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic chk_counts(input string req);
    chk(req, "filled count", cnt_fill, exp_fill);
    chk(req, "empty count", cnt_empty, exp_empty);
  endtask

  task automatic chk_issue(input string req);
    int st = pair_status();
    for (int l = 0; l < 6; l++) begin
      bit ev = (st == 0) && (s[l][40:37] != 0);
      chk(req, $sformatf("lane%0d valid", l), lane_valid[l], ev);
      if (ev) begin
        chk(req, $sformatf("lane%0d op", l), lane_op[l*4 +: 4], s[l][40:37]);
        chk(req, $sformatf("lane%0d imm", l), lane_imm[l*16 +: 16], s[l][36:21]);
        chk(req, $sformatf("lane%0d src2", l), lane_src2[l*7 +: 7], s[l][20:14]);
        chk(req, $sformatf("lane%0d src1", l), lane_src1[l*7 +: 7], s[l][13:7]);
        chk(req, $sformatf("lane%0d dst", l), lane_dst[l*7 +: 7], s[l][6:0]);
        chk(req, $sformatf("lane%0d cls", l), lane_cls[l*2 +: 2], tb_cls(tm[l/3], l%3));
      end
    end
    chk(req, "err_tmpl", err_tmpl, st == 2);
    chk(req, "err_cls", err_cls, st == 1);
    chk_counts(req);
  endtask

  task automatic load_full();
    tm[0] = 5'd0; tm[1] = 5'd4;
    s[0] = mk_s(4'd5,  16'hA5A5, 7'd1,  7'd2,  7'd3);
    s[1] = mk_s(4'd1,  16'h1234, 7'd10, 7'd11, 7'd12);
    s[2] = mk_s(4'd3,  16'hFFFF, 7'd127,7'd0,  7'd64);
    s[3] = mk_s(4'd2,  16'h0001, 7'd20, 7'd21, 7'd22);
    s[4] = mk_s(4'd1,  16'h8000, 7'd30, 7'd31, 7'd32);
    s[5] = mk_s(4'd12, 16'h0F0F, 7'd40, 7'd41, 7'd42);
  endtask

  task automatic load_sparse();
    tm[0] = 5'd2; tm[1] = 5'd6;
    s[0] = mk_s(4'd7, 16'h0042, 7'd5, 7'd6, 7'd7);
    s[1] = '0;
    s[2] = mk_s(4'd2, 16'h7777, 7'd8, 7'd9, 7'd100);
    s[3] = '0;
    s[4] = mk_s(4'd9, 16'hBEEF, 7'd50, 7'd51, 7'd52);
    s[5] = '0;
  endtask

  task automatic t_reset();
    chk("R10", "lane valid", lane_valid, 0);
    chk("R10", "err_tmpl", err_tmpl, 0);
    chk("R10", "err_cls", err_cls, 0);
    chk_counts("R10");
    chk("R4", "in_ready all ready", in_ready, 1);
  endtask

  task automatic t_full();
    load_full();
    send_pair();
    chk_issue("R5");
    @(negedge clk);
    chk("R11", "lane valid idle", lane_valid, 0);
    chk("R11", "err flags idle", {err_tmpl, err_cls}, 0);
  endtask

  task automatic t_sparse();
    load_sparse();
    send_pair();
    chk_issue("R9");
    chk("R5", "empty lanes low", lane_valid, 6'b010101);
    @(negedge clk);
  endtask

  task automatic t_mismatch();
    load_full();
    s[1] = mk_s(4'd8, 16'h0, 7'd1, 7'd1, 7'd1);  // fp in an int slot
    send_pair();
    chk_issue("R7");
    @(negedge clk);
    chk("R7", "err_cls one cycle", err_cls, 0);
    chk_counts("R7");
  endtask

  task automatic t_illegal();
    load_full();
    tm[1] = 5'd20;
    send_pair();
    chk_issue("R8");
    @(negedge clk);
    chk("R8", "err_tmpl one cycle", err_tmpl, 0);
    chk_counts("R8");
  endtask

  task automatic t_backpressure();
    logic [40:0] a2;
    load_full();
    send_pair();
    a2 = s[2];
    lane_ready = 6'b111011;
    load_sparse();
    present();
    #1;
    chk("R4", "in_ready one lane busy", in_ready, 0);
    @(posedge clk);
    @(negedge clk);
    chk("R6", "only stalled lane valid", lane_valid, 6'b000100);
    chk("R6", "stalled lane op", lane_op[8 +: 4], a2[40:37]);
    chk("R6", "stalled lane dst", lane_dst[14 +: 7], a2[6:0]);
    chk_counts("R4");
    lane_ready = '1;
    @(posedge clk);
    model_take();
    @(negedge clk);
    in_valid = 1'b0;
    chk_issue("R4");
    @(negedge clk);
  endtask

  task automatic t_saturate();
    load_sparse();
    for (int i = 0; i < 6; i++) send_pair();
    chk("R9", "filled saturated", cnt_fill, CMAX);
    chk("R9", "empty saturated", cnt_empty, CMAX);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_full();
    t_sparse();
    t_mismatch();
    t_illegal();
    t_backpressure();
    t_saturate();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule